// File: doc/BRIEF.md
# Interleaved Hysteretic Regulator Controller

This block is the digital control core of a switched-capacitor step-down regulator made of ten interleaved power phases. On every clock edge it looks at a single comparator bit that reports whether the regulated output is below its target. If the output is low and the controller is enabled, it issues one charge-injection strobe. That strobe goes to exactly one phase, and successive strobes walk through the phases in a fixed rotating order. The result is a one-cycle hysteretic loop that spreads charge evenly across the interleaved converters.

The block also owns the conversion-ratio select that is shared by all phases. Codes 0 to 6 pick one of seven step-down ratios, running from 4:1 (code 0) to 4:3 (code 6). A new ratio is only applied on an edge where no injection is issued, so no phase is ever pulsed while the ratio setting is changing. Code 7 is rejected: the current ratio is kept and an error flag is raised.

A small state machine with three states tracks the controller:
- `ST_OFF`: enable is low.
- `ST_REGULATE`: normal hysteretic operation.
- `ST_SHIFT_WAIT`: a valid ratio request differs from the applied ratio but was held back by an injection.

The transitions are:
- Any state goes to `ST_OFF` when enable is low.
- Otherwise, the machine enters `ST_SHIFT_WAIT` when an injection edge meets a pending ratio change.
- In every other case it goes to `ST_REGULATE`.

Top module: `ihr_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the outputs are `inj` = 0, `ratio_sel` = 0, `busy` = 0 and `ratio_err` = 0. The first injection after reset goes to phase 0 (`inj` bit 0).
- R2: At a clock edge with `en`=1 and `cmp_low`=1, `inj` shows a one-hot strobe for the phase under the rotation pointer during the following cycle. With `cmp_low`=0 at that edge, `inj` is 0 during the following cycle.
- R3: At most one bit of `inj` is high in any cycle.
- R4: The rotation pointer advances by one only on an edge that issues an injection, and it wraps from phase 9 to phase 0.
- R5: Each strobe on a given `inj` bit lasts exactly one clock cycle.
- R6: At an edge with `en`=0, `inj` becomes 0 and the pointer returns to phase 0, so the next injection goes to `inj` bit 0.
- R7: `ratio_req` codes 0 to 6 select ratios 4:1 through 4:3. A valid request that differs from `ratio_sel` is applied at an edge where no injection is issued, and `ratio_sel` shows it in the following cycle.
- R8: If a valid differing request meets an injection edge, `ratio_sel` is held and `busy` is 1 in the following cycle. The request is then applied at the first edge without an injection.
- R9: `ratio_req` = 7 is ignored: `ratio_sel` holds its value, and `ratio_err` is 1 in the cycle after any edge that sees code 7. Otherwise `ratio_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable; low blocks injections and rewinds rotation |
| cmp_low | input | 1 | Comparator result, 1 = output below target |
| ratio_req | input | 3 | Requested conversion ratio code (0..6 valid, 7 invalid) |
| inj | output | 10 | Per-phase charge-injection strobes, one-hot or zero |
| ratio_sel | output | 3 | Applied conversion ratio code shared by all phases |
| busy | output | 1 | A ratio change is pending behind an injection |
| ratio_err | output | 1 | The previous edge saw an invalid ratio code |

## Verification
A corrupted rotation pointer appears at `inj` on the very next injection: the strobe lands on the wrong bit, or two bits are high together. Each strobe is compared against a bench model of the pointer on every cycle. A wrong ratio latch or a wrong state shows up one cycle after the edge that should have applied or deferred the change, either as a `ratio_sel` value that moved during an injection or as a `busy` value that disagrees with the model. Random comparator and enable patterns are interleaved with ratio requests that land on injection edges, and with invalid codes, so these faults are exercised within a few cycles of one another.

// File: rtl/ihr_pkg.sv
package ihr_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_REGULATE,
        ST_SHIFT_WAIT
    } ctrl_state_e;
endpackage

// File: rtl/ihr_rotor.sv
module ihr_rotor #(
    parameter int NUM_PH = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fire,
    output logic [NUM_PH-1:0] inj
);
    localparam int PTR_W = (NUM_PH > 1) ? $clog2(NUM_PH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_PH - 1);

    logic [PTR_W-1:0]  ptr_q;
    logic [NUM_PH-1:0] sel_dec;
    logic [NUM_PH-1:0] inj_q;

    generate
        for (genvar g = 0; g < NUM_PH; g++) begin : g_dec
            assign sel_dec[g] = (ptr_q == PTR_W'(g));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            inj_q <= '0;
        end else if (!en) begin
            ptr_q <= '0;
            inj_q <= '0;
        end else if (fire) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
            inj_q <= sel_dec;
        end else begin
            inj_q <= '0;
        end
    end

    assign inj = inj_q;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inj_q)); // R3
    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (inj_q == '0)); // R6

    generate
        if (NUM_PH > 1) begin : g_width
            for (genvar w = 0; w < NUM_PH; w++) begin : g_w
                AST_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
                    inj_q[w] |=> !inj_q[w]); // R5
            end
        end
    endgenerate
endmodule

// File: rtl/ihr_gear.sv
module ihr_gear #(
    parameter int RATIO_W    = 3,
    parameter int NUM_RATIOS = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] req,
    input  logic               allow,
    output logic [RATIO_W-1:0] ratio_sel,
    output logic               mismatch,
    output logic               err
);
    localparam logic [RATIO_W-1:0] LIMIT = RATIO_W'(NUM_RATIOS);

    logic [RATIO_W-1:0] ratio_q;
    logic               err_q;
    logic               valid;

    assign valid    = (req < LIMIT);
    assign mismatch = valid && (req != ratio_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= !valid;
            if (allow && mismatch) begin
                ratio_q <= req;
            end
        end
    end

    assign ratio_sel = ratio_q;
    assign err       = err_q;

    AST_HOLD_ON_INJ: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |=> $stable(ratio_q)); // R8
    AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> ($stable(ratio_q) && err_q)); // R9
endmodule

// File: rtl/ihr_ctrl.sv
module ihr_ctrl #(
    parameter int NUM_PH     = 10,
    parameter int RATIO_W    = 3,
    parameter int NUM_RATIOS = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               cmp_low,
    input  logic [RATIO_W-1:0] ratio_req,
    output logic [NUM_PH-1:0]  inj,
    output logic [RATIO_W-1:0] ratio_sel,
    output logic               busy,
    output logic               ratio_err
);
    import ihr_pkg::*;

    ctrl_state_e state_q, state_d;
    logic        fire;
    logic        mismatch;

    assign fire = en && cmp_low;

    ihr_rotor #(.NUM_PH(NUM_PH)) u_rotor (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .fire  (fire),
        .inj   (inj)
    );

    ihr_gear #(.RATIO_W(RATIO_W), .NUM_RATIOS(NUM_RATIOS)) u_gear (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ratio_req),
        .allow     (!fire),
        .ratio_sel (ratio_sel),
        .mismatch  (mismatch),
        .err       (ratio_err)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF, ST_REGULATE, ST_SHIFT_WAIT: begin
                if (!en)                       state_d = ST_OFF;
                else if (fire && mismatch)     state_d = ST_SHIFT_WAIT;
                else                           state_d = ST_REGULATE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        busy = (state_q == ST_SHIFT_WAIT);
    end

    AST_FIRE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (inj != '0)); // R2
    AST_RATIO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_sel) |-> (inj == '0)); // R7
endmodule

// File: tb/ihr_ctrl_tb.sv
module ihr_ctrl_tb;
    localparam int NPH = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en = 1'b0;
    logic           cmp_low = 1'b0;
    logic [2:0]     ratio_req = 3'd0;
    logic [NPH-1:0] inj;
    logic [2:0]     ratio_sel;
    logic           busy;
    logic           ratio_err;

    int checks = 0;
    int errors = 0;

    int             m_ptr = 0;
    logic [2:0]     m_ratio = 3'd0;
    logic           m_busy = 1'b0;
    logic           m_err = 1'b0;
    logic [NPH-1:0] m_inj = '0;
    logic [NPH-1:0] prev_inj = '0;

    always #4 clk = ~clk;

    ihr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cmp_low(cmp_low),
        .ratio_req(ratio_req), .inj(inj), .ratio_sel(ratio_sel),
        .busy(busy), .ratio_err(ratio_err)
    );

    function automatic logic [NPH-1:0] onehot(input int p);
        logic [NPH-1:0] v;
        v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        logic fire, valid, diff;
        @(posedge clk);
        fire  = en && cmp_low;
        valid = (ratio_req != 3'd7);
        diff  = valid && (ratio_req != m_ratio);
        m_inj = fire ? onehot(m_ptr) : '0;
        if (!en) m_ptr = 0;
        else if (fire) m_ptr = (m_ptr == NPH-1) ? 0 : m_ptr + 1;
        m_busy = en && fire && diff;
        if (diff && !fire) m_ratio = ratio_req;
        m_err = !valid;
        @(negedge clk);
        check({tag, " R2 inj"}, 32'(inj), 32'(m_inj));
        check("R3 onehot", 32'($countones(inj) <= 1), 32'd1);
        check("R5 width", 32'(inj & prev_inj), 32'd0);
        check({tag, " R7 ratio_sel"}, 32'(ratio_sel), 32'(m_ratio));
        check({tag, " R8 busy"}, 32'(busy), 32'(m_busy));
        check({tag, " R9 ratio_err"}, 32'(ratio_err), 32'(m_err));
        prev_inj = inj;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 inj", 32'(inj), 32'd0);
        check("R1 ratio_sel", 32'(ratio_sel), 32'd0);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 ratio_err", 32'(ratio_err), 32'd0);
        rst_n = 1'b1;
        en = 1'b1;
        cmp_low = 1'b1;
        step("R1 first");
        check("R1 first phase", 32'(inj), 32'd1);
        // R4 wrap: twelve injections in a row
        for (int i = 0; i < 12; i++) step("R4 wrap");
        // R4 no advance without injection
        cmp_low = 1'b0;
        repeat (3) step("R4 hold");
        cmp_low = 1'b1;
        step("R4 resume");
        // R8 change on injection edge, then apply when idle
        ratio_req = 3'd5;
        step("R8 defer");
        check("R8 busy set", 32'(busy), 32'd1);
        cmp_low = 1'b0;
        step("R8 apply");
        check("R7 applied", 32'(ratio_sel), 32'd5);
        // R9 invalid code
        ratio_req = 3'd7;
        repeat (2) step("R9 bad");
        check("R9 held", 32'(ratio_sel), 32'd5);
        // R6 disable rewinds pointer
        ratio_req = 3'd2;
        cmp_low = 1'b1;
        repeat (4) step("R6 pre");
        en = 1'b0;
        step("R6 off");
        en = 1'b1;
        step("R6 rewind");
        check("R6 phase0", 32'(inj), 32'd1);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            en        = ($urandom % 16) != 0;
            cmp_low   = ($urandom % 3) != 0;
            ratio_req = ($urandom % 5 == 0) ? 3'($urandom % 8) : ratio_req;
            step("RND");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule